// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an eight-pin bidirectional I/O port through a small register bus. Software sets each pin's direction and output data. It reads back either the data latch or the live pin levels. Pins set as outputs drive the latch value onto the pad with their output enable asserted. Pins set as inputs leave their driver tri-stated.

Each pin has a weak pull-up enable. One active-low global control bit switches all the pull-ups on together. Any pin set as an output has its pull-up forced off. The five low pins can be marked analog; an analog pin always reads as zero through the pin register. A configuration strap, sampled during reset, picks whether those five pins leave reset as analog or digital. Pad inputs cross a two-flop synchronizer before they are read.

The bus takes a write strobe, a read strobe and a two-bit register select. Writes take effect at the clock edge. Read data is combinational from the selected register while the read strobe is high.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it, before any write: the direction register reads 0xFF at select 2, the latch reads 0x00 at select 1, `pad_oe` is 0x00 and `pu_en` is 0x00.
- R2: The control register sits at select 3. Bit 7 is the active-low global pull-up enable and resets to 1. Bits 4:0 are the analog-select bits, with 1 meaning analog. After reset these read 0x1F when `cfg_ana_strap` is 1 and 0x00 when it is 0. Writes to bits 7 and 4:0 take effect at the next clock edge.
- R3: `pad_oe[i]` is the inverse of direction bit i, where 1 means input. `pad_out` always equals the output latch.
- R4: A write to select 0 or to select 1 loads the output latch. A read of select 1 returns the latch and not the pin levels.
- R5: A read of select 0 returns the pad levels sampled two clock edges earlier, for digital pins.
- R6: `pu_en[i]` is 1 exactly when control bit 7 is 0 and direction bit i is 1.
- R7: A pin among 4:0 whose analog-select bit is 1 reads as 0 at select 0, whatever its pad level. Control bits 6:5 ignore writes and read as 0.
- R8: A write to select 2 loads the direction register, which reads back unchanged at select 2.
- R9: `rd_data` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cfg_ana_strap | input | 1 | Reset default for pins 4:0: 1 means analog, 0 means digital |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| pad_in | input | 8 | Raw pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 means drive |
| pu_en | output | 8 | Weak pull-up enables, 1 means on |

## Verification
The register-update assertions assume that `wr_en` and `reg_sel` are stable across the clock edge. The bench therefore changes every bus input only on the falling edge. The read-masking assertion assumes `reg_sel` already decodes when `rd_en` is high, so the bench sets the select in the same half-cycle as the strobe. The synchronizer property assumes `pad_in` may change at any time. The bench moves it only on falling edges and waits two rising edges before it reads the pin register. Direction with the pull-up bit, and pad levels with the analog mask, are swept over all 256 values for each setting.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int ANA_W  = 5;
    localparam int SEL_W  = 2;
    localparam int SYNC_N = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_PINS  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             pu_off_n;
        logic [ANA_W-1:0] ana;
    } ctrl_t;

    // Widen the analog-select bits to a port-wide mask.
    function automatic logic [PORT_W-1:0] ana_mask(input logic [ANA_W-1:0] ana);
        logic [PORT_W-1:0] m;
        m = '0;
        m[ANA_W-1:0] = ana;
        return m;
    endfunction

    // Place the control fields at their read-back positions.
    function automatic logic [PORT_W-1:0] pack_ctrl(input ctrl_t c);
        logic [PORT_W-1:0] v;
        v = '0;
        v[PORT_W-1]  = c.pu_off_n;
        v[ANA_W-1:0] = c.ana;
        return v;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [N];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < N; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[N-1];

    AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stg[N-1] == $past(stg[N-2]));  // R5

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PW = PORT_W,
    parameter int AW = ANA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_ana_strap,
    input  logic           wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [PW-1:0]  wdata,
    output logic [PW-1:0]  dir_q,
    output logic [PW-1:0]  lat_q,
    output ctrl_t          ctrl_q
);
    localparam int PU_BIT = PW - 1;

    logic wr_pins, wr_lat, wr_dir, wr_ctl;

    always_comb begin
        wr_pins = wr_en && (reg_sel_e'(sel) == SEL_PINS);
        wr_lat  = wr_en && (reg_sel_e'(sel) == SEL_LATCH);
        wr_dir  = wr_en && (reg_sel_e'(sel) == SEL_DIR);
        wr_ctl  = wr_en && (reg_sel_e'(sel) == SEL_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
            ctrl_q.pu_off_n <= 1'b1;
            ctrl_q.ana      <= {AW{cfg_ana_strap}};
        end else begin
            if (wr_dir)            dir_q <= wdata;
            if (wr_pins || wr_lat) lat_q <= wdata;
            if (wr_ctl) begin
                ctrl_q.pu_off_n <= wdata[PU_BIT];
                ctrl_q.ana      <= wdata[AW-1:0];
            end
        end
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == SEL_DIR |=> dir_q == $past(wdata));  // R8
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en && (sel == SEL_PINS || sel == SEL_LATCH) |=> lat_q == $past(wdata));  // R4
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == SEL_CTRL |=> ctrl_q.pu_off_n == $past(wdata[PU_BIT])
                                     && ctrl_q.ana == $past(wdata[AW-1:0]));  // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(lat_q));  // R4

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int PW = PORT_W,
    parameter int AW = ANA_W
) (
    input  logic [PW-1:0] dir,
    input  logic [PW-1:0] lat,
    input  logic          pu_off_n,
    input  logic [AW-1:0] ana,
    input  logic [PW-1:0] pin_sync,
    output logic [PW-1:0] oe,
    output logic [PW-1:0] dout,
    output logic [PW-1:0] pu,
    output logic [PW-1:0] pin_view
);
    for (genvar i = 0; i < PW; i++) begin : g_pin
        assign oe[i]   = ~dir[i];
        assign dout[i] = lat[i];
        assign pu[i]   = ~pu_off_n & dir[i];
        if (i < AW) begin : g_ana
            assign pin_view[i] = pin_sync[i] & ~ana[i];
        end else begin : g_dig
            assign pin_view[i] = pin_sync[i];
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ana_strap,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pu_en
);
    logic [PORT_W-1:0] dir_q, lat_q, pin_sync, pin_view;
    ctrl_t             ctrl_q;

    gpio_sync #(.W(PORT_W), .N(SYNC_N)) u_sync (
        .clk (clk), .rst (rst), .d (pad_in), .q (pin_sync)
    );

    gpio_regs #(.PW(PORT_W), .AW(ANA_W)) u_regs (
        .clk (clk), .rst (rst), .cfg_ana_strap (cfg_ana_strap),
        .wr_en (wr_en), .sel (reg_sel), .wdata (wr_data),
        .dir_q (dir_q), .lat_q (lat_q), .ctrl_q (ctrl_q)
    );

    gpio_pad_ctl #(.PW(PORT_W), .AW(ANA_W)) u_pad (
        .dir (dir_q), .lat (lat_q), .pu_off_n (ctrl_q.pu_off_n),
        .ana (ctrl_q.ana), .pin_sync (pin_sync),
        .oe (pad_oe), .dout (pad_out), .pu (pu_en), .pin_view (pin_view)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_PINS:  rd_data = pin_view;
                SEL_LATCH: rd_data = lat_q;
                SEL_DIR:   rd_data = dir_q;
                SEL_CTRL:  rd_data = pack_ctrl(ctrl_q);
                default:   rd_data = '0;
            endcase
        end
    end

    AST_PU_OUTPUT_OFF: assert property (@(posedge clk) disable iff (rst)
        (pu_en & pad_oe) == '0);  // R6
    AST_ANA_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en && reg_sel == SEL_PINS |-> (rd_data & ana_mask(ctrl_q.ana)) == '0);  // R7
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);  // R9
    AST_OUT_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (rst)
        wr_en && reg_sel == SEL_LATCH |=> pad_out == $past(wr_data));  // R3

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00, pad_in = 8'h00;
    logic [7:0] rd_data, pad_out, pad_oe, pu_en;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk (clk), .rst (rst), .cfg_ana_strap (strap),
        .wr_en (wr_en), .rd_en (rd_en), .reg_sel (reg_sel),
        .wr_data (wr_data), .rd_data (rd_data), .pad_in (pad_in),
        .pad_out (pad_out), .pad_oe (pad_oe), .pu_en (pu_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap = s; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        do_reset(1'b1);
        // R1 reset state
        bus_rd(2'd2, v); chk("R1 dir reset", v, 8'hFF);
        bus_rd(2'd1, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 pad_oe reset", pad_oe, 8'h00);
        chk("R1 pu_en reset", pu_en, 8'h00);
        // R2 strap=1
        bus_rd(2'd3, v); chk("R2 ctrl strap1", v, 8'h9F);
        // R9 idle bus
        #1 chk("R9 idle rd_data", rd_data, 8'h00);
        // R2 strap=0
        do_reset(1'b0);
        bus_rd(2'd3, v); chk("R2 ctrl strap0", v, 8'h80);
        // R7 bits 6:5 ignore writes
        bus_wr(2'd3, 8'h60);
        bus_rd(2'd3, v); chk("R7 ctrl bits6:5", v, 8'h00);
        // R4 latch via select 0 and 1, pad_out follows (R3)
        bus_wr(2'd0, 8'hA5);
        bus_rd(2'd1, v); chk("R4 latch via sel0", v, 8'hA5);
        chk("R3 pad_out", pad_out, 8'hA5);
        bus_wr(2'd1, 8'h3C);
        bus_rd(2'd1, v); chk("R4 latch via sel1", v, 8'h3C);
        chk("R3 pad_out", pad_out, 8'h3C);
        // R4 latch read is not pin level
        @(negedge clk); pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        bus_rd(2'd1, v); chk("R4 latch not pins", v, 8'h3C);
        // R8 / R3 / R6 sweep direction x pull-up bit
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 256; d++) begin
                bus_wr(2'd3, p[0] ? 8'h80 : 8'h00);
                bus_wr(2'd2, d[7:0]);
                bus_rd(2'd2, v); chk("R8 dir readback", v, d[7:0]);
                chk("R3 pad_oe", pad_oe, ~d[7:0]);
                chk("R6 pu_en", pu_en, p[0] ? 8'h00 : d[7:0]);
            end
        end
        // R5 / R7 sweep pad levels x analog mask
        for (int m = 0; m < 3; m++) begin
            logic [7:0] am;
            am = (m == 0) ? 8'h00 : (m == 1) ? 8'h1F : 8'h0A;
            bus_wr(2'd3, am);
            for (int x = 0; x < 256; x++) begin
                @(negedge clk); pad_in = x[7:0];
                @(posedge clk); @(posedge clk);
                bus_rd(2'd0, v);
                chk(m == 0 ? "R5 pin read" : "R7 analog mask", v, x[7:0] & ~am);
            end
        end
        // R5 two-edge latency: value not visible after one edge
        @(negedge clk); pad_in = 8'h00;
        bus_wr(2'd3, 8'h80);
        repeat (3) @(negedge clk);
        pad_in = 8'hC3;
        @(posedge clk);
        @(negedge clk); reg_sel = 2'd0; rd_en = 1'b1;
        #1 chk("R5 one edge", rd_data, 8'h00);
        @(posedge clk);
        #1 chk("R5 two edges", rd_data, 8'hC3);
        @(negedge clk); rd_en = 1'b0;
        #1 chk("R9 rd_en low", rd_data, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule